// File: doc/BRIEF.md
# Burst Offset Sequencer

This block generates the low-order offset bits for a four-beat memory burst. When a burst begins it captures a starting offset from the external address. Each time the controller asks for the next beat, it moves to the next position of the burst. A static order input chooses between two orders: a wrapping increment, or a pattern in which the start offset is exclusive-ORed with a running beat count. After four steps the sequence returns to the start offset, and stepping further repeats the same four values.

Internally the block stores only the captured start offset and a beat count. The presented offset is computed from those two values and the order input. A separate output pulses for one cycle after every accepted step, so a test environment can see beat boundaries. Upper address bits, storage and command decode belong to the surrounding logic. This block sees only its load and advance strobes.

Top module: `burst_ofs_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `ofs` is 00 and `beat_done` is 0.
- R2: `order_il` = 0 selects the wrapping-increment order and `order_il` = 1 selects the exclusive-OR order. The order input acts combinationally on `ofs`.
- R3: In increment order, beat k of a burst that starts at offset s presents (s + k) mod 4. From starts 00, 01, 10 and 11 this gives 00 01 10 11, 01 10 11 00, 10 11 00 01 and 11 00 01 10.
- R4: In exclusive-OR order, beat k of a burst that starts at s presents s XOR k. From starts 00, 01, 10 and 11 this gives 00 01 10 11, 01 00 11 10, 10 11 00 01 and 11 10 01 00.
- R5: A clock edge with `load` = 1 captures `start_ofs`. From the next cycle `ofs` equals that value (beat 0) in either order.
- R6: A clock edge with `advance` = 1 and `load` = 0 moves the burst one beat on. The new offset appears in the following cycle.
- R7: A clock edge with both `load` and `advance` low leaves `ofs` unchanged (burst suspended).
- R8: Four consecutive advances after a load bring `ofs` back to the loaded start offset, and the sequence then repeats.
- R9: When `load` and `advance` are both high at the same edge, the load takes effect and the beat count restarts at 0, so `ofs` equals the new start offset.
- R10: `beat_done` is 1 for exactly one cycle after each edge with `advance` = 1 and `load` = 0. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| order_il | input | 1 | Burst order: 0 increment, 1 exclusive-OR |
| load | input | 1 | Start a burst from `start_ofs` |
| advance | input | 1 | Step to the next beat |
| start_ofs | input | 2 | External low address bits captured on load |
| ofs | output | 2 | Current burst offset |
| beat_done | output | 1 | One-cycle pulse after each accepted step |

## Verification
Every start offset is loaded in both orders and then stepped five times. This checks the full table of each order and also the return to the start on the fifth beat. Start offset 10 gives the same sequence in both orders, while 01 and 11 give different ones, so these starts show whether the order input is decoded correctly. Stretches with neither strobe high separate a true hold from a counter that creeps forward. Cycles with load and advance high together show whether the load takes priority, and changing the order input at a load shows whether the output follows the order input without any delay.

// File: rtl/burst_ofs_pkg.sv
package burst_ofs_pkg;

  typedef enum logic {
    ORD_INCR = 1'b0,
    ORD_XOR  = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [OFS_W-1:0] start_in,
  output logic [OFS_W-1:0] start_q,
  output logic [OFS_W-1:0] beat_q,
  output logic             step_pulse
);

  localparam logic [OFS_W-1:0] LAST_BEAT = {OFS_W{1'b1}};

  // named internal events, also used by the assertions
  logic do_load;
  logic do_step;

  assign do_load = load;
  assign do_step = advance && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= '0;
      beat_q     <= '0;
      step_pulse <= 1'b0;
    end else begin
      if (do_load) begin
        start_q <= start_in;
        beat_q  <= '0;
      end else if (do_step) begin
        beat_q <= beat_q + 1'b1;
      end
      step_pulse <= do_step;
    end
  end

  // R9: load has priority, the beat count restarts
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load && advance) |=> (beat_q == '0));

  // R7: without strobes the state is frozen
  a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(beat_q) && $stable(start_q)));

  // R8: the last beat wraps to beat zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && beat_q == LAST_BEAT) |=> (beat_q == '0));

  // R10: pulse follows accepted steps only
  a_r10_pulse_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> step_pulse);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && !load) |=> !step_pulse);

endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_ofs_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  burst_order_e     order,
  input  logic [OFS_W-1:0] start_q,
  input  logic [OFS_W-1:0] beat_q,
  output logic [OFS_W-1:0] ofs
);

  function automatic logic [OFS_W-1:0] incr_ofs(input logic [OFS_W-1:0] s,
                                                input logic [OFS_W-1:0] b);
    return s + b;
  endfunction

  function automatic logic [OFS_W-1:0] xor_ofs(input logic [OFS_W-1:0] s,
                                               input logic [OFS_W-1:0] b);
    return s ^ b;
  endfunction

  always_comb begin
    unique case (order)
      ORD_XOR: ofs = xor_ofs(start_q, beat_q);
      default: ofs = incr_ofs(start_q, beat_q);
    endcase
  end

  // R4: in XOR order, beat zero always reproduces the start
  always_comb begin
    if (order == ORD_XOR && beat_q == '0)
      a_r4_xor_base: assert (ofs == start_q);
  end

endmodule

// File: rtl/burst_ofs_gen.sv
module burst_ofs_gen
  import burst_ofs_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             order_il,
  input  logic             load,
  input  logic             advance,
  input  logic [OFS_W-1:0] start_ofs,
  output logic [OFS_W-1:0] ofs,
  output logic             beat_done
);

  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  burst_order_e     order;

  assign order = burst_order_e'(order_il);

  burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .advance    (advance),
    .start_in   (start_ofs),
    .start_q    (start_q),
    .beat_q     (beat_q),
    .step_pulse (beat_done)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .order   (order),
    .start_q (start_q),
    .beat_q  (beat_q),
    .ofs     (ofs)
  );

  // R5: a load shows the captured offset in the next cycle
  a_r5_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ofs == $past(start_ofs)));

  // R3: increment order steps the offset by one
  a_r3_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!order_il && advance && !load) |=> (order_il || ofs == $past(ofs) + 1'b1));

  // R7: suspend keeps the offset while the order is unchanged
  a_r7_hold_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> (!$stable(order_il) || $stable(ofs)));

endmodule

// File: tb/sim_burst_ofs_gen.sv
module sim_burst_ofs_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       order_il = 1'b0;
  logic       load = 1'b0;
  logic       advance = 1'b0;
  logic [1:0] start_ofs = 2'b00;
  logic [1:0] ofs;
  logic       beat_done;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_start = 0;
  int m_beat  = 0;
  bit m_done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_ofs_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_il  (order_il),
    .load      (load),
    .advance   (advance),
    .start_ofs (start_ofs),
    .ofs       (ofs),
    .beat_done (beat_done)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0;
      m_beat  = 0;
      m_done  = 0;
    end else begin
      m_done = advance && !load;
      if (load) begin
        m_start = int'(start_ofs);
        m_beat  = 0;
      end else if (advance) begin
        m_beat = (m_beat == 3) ? 0 : m_beat + 1;
      end
    end
  end

  function automatic int model_ofs(input bit il);
    if (il) return m_start ^ m_beat;
    return (m_start + m_beat) % 4;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // at a negative edge: compare, then drive the next inputs
  task automatic cyc(input bit ld, input bit adv, input int st, input bit il);
    @(negedge clk);
    check(cur_req, int'(ofs), model_ofs(order_il), "ofs");
    check("R10", int'(beat_done), int'(m_done), "beat_done");
    load      = ld;
    advance   = adv;
    start_ofs = st[1:0];
    order_il  = il;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(ofs), 0, "ofs in reset");
    check("R1", int'(beat_done), 0, "beat_done in reset");
    rst_n = 1'b1;
    cur_req = "R1";
    cyc(0, 0, 0, 0);

    // R3 and R4 tables, with R8 wrap on the fifth beat
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        cur_req = il ? "R4" : "R3";
        cyc(1, 0, s, il[0]);
        for (int k = 0; k < 4; k++) cyc(0, 1, 0, il[0]);
        cur_req = "R8";
        cyc(0, 1, 0, il[0]);
        cyc(0, 0, 0, il[0]);
        @(negedge clk);
        check("R8", int'(ofs), (il ? (s ^ 1) : ((s + 1) % 4)), "beat after wrap");
      end
    end

    // R5: the captured value appears as beat zero
    cur_req = "R5";
    cyc(1, 0, 2, 1);
    cyc(0, 0, 0, 1);
    check("R5", int'(ofs), 2, "first beat");

    // R7: suspend in the middle of a burst
    cur_req = "R7";
    cyc(1, 0, 3, 0);
    cyc(0, 1, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0);
    @(negedge clk);
    check("R7", int'(ofs), 0, "held offset");

    // R2: the order input switches the output without delay
    cur_req = "R2";
    cyc(1, 0, 1, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    @(negedge clk);
    check("R2", int'(ofs), 2, "incr beat1 from 01");
    order_il = 1'b1;
    #1;
    check("R2", int'(ofs), 0, "xor beat1 from 01");

    // R9: load and advance together
    cur_req = "R9";
    cyc(0, 1, 0, 1);
    cyc(1, 1, 2, 1);
    cyc(0, 0, 0, 1);
    @(negedge clk);
    check("R9", int'(ofs), 2, "load priority");

    // R6: mixed pattern of strobes
    cur_req = "R6";
    for (int i = 0; i < 200; i++)
      cyc(((i % 7) == 0), ((i % 3) != 1), (i * 5) % 4, ((i / 23) % 2) == 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);

    finish_run();
  end

endmodule